// File: doc/BRIEF.md
# Video Palette Memory with Backdrop Resolution

This block holds the colour palette of a tile-based video generator: 32 six-bit colour entries that the CPU writes and reads through a 14-bit video address, and that the renderer reads once per pixel. For each pixel the renderer presents a sprite/background flag, a 2-bit sub-palette selector and a 2-bit pattern value. The block returns a 6-bit colour index one clock later, together with the three colour-emphasis bits of the display control byte.

A pixel whose pattern value is zero takes the backdrop colour. The backdrop normally comes from entry 0. While rendering is off and the current video address points into the palette page, the backdrop comes from the entry that address selects, so software that updates the palette outside the active display sees its writes on screen. Grayscale mode keeps only the two upper bits of every colour the palette gives out, on the pixel path and on CPU readback alike. CPU reads of palette space return data in the same cycle. Reads of other video memory go through a one-read delay buffer, which this block holds and fills from the video memory data bus.

Top module: `video_palette`

## Requirements
- R1: After reset, out_valid is 0, every palette entry reads as 0, and the first non-palette CPU read returns 0.
- R2: A CPU write to a palette address (top six address bits all ones, i.e. 0x3F00-0x3FFF) stores the low 6 data bits. A palette read returns that entry on cpu_rdata in the same cycle, with bits 7-6 zero.
- R3: Palette indices 0x10, 0x14, 0x18 and 0x1C share storage with 0x00, 0x04, 0x08 and 0x0C, for both writes and reads.
- R4: Only the low 5 address bits select the entry, so the palette page repeats every 32 addresses up to 0x3FFF.
- R5: A CPU read outside the palette page returns the vram_rdata value captured by the previous non-palette read, then captures the current one. Palette reads leave that buffer unchanged.
- R6: A pixel with pix_valid and a non-zero pattern value gives, on the next cycle, out_valid=1 and the entry at index {pix_sprite, pix_sel, pix_bits}. When pix_valid is low, out_valid is low on the next cycle.
- R7: A pixel with pattern value 0 while render_en=1 gives entry 0, whatever the current address.
- R8: A pixel with pattern value 0 while render_en=0 and cpu_addr inside the palette page gives the entry that cpu_addr selects, aliases included.
- R9: A pixel with pattern value 0 while render_en=0 and cpu_addr outside the palette page gives entry 0.
- R10: While disp_ctrl bit 0 (grayscale) is 1, out_color is the selected colour ANDed with 0x30.
- R11: While disp_ctrl bit 0 is 1, palette readback is ANDed with 0x30, so bits 3-0 read 0.
- R12: out_emph carries disp_ctrl bits 7-5 from the cycle the pixel was presented, aligned with out_color.
- R13: CPU writes to addresses outside the palette page leave every palette entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 14 | Current video address (CPU access address and backdrop pointer) |
| cpu_wr_en | input | 1 | CPU write strobe for one cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd_en | input | 1 | CPU read strobe for one cycle |
| cpu_rdata | output | 8 | CPU read data (palette or delayed video memory byte) |
| vram_rdata | input | 8 | Byte from video memory at cpu_addr |
| render_en | input | 1 | Rendering enabled |
| disp_ctrl | input | 8 | Display control byte: bit 0 grayscale, bits 7-5 emphasis |
| pix_valid | input | 1 | Pixel request valid |
| pix_sprite | input | 1 | Pixel uses the sprite half of the palette |
| pix_sel | input | 2 | Sub-palette selector |
| pix_bits | input | 2 | Pattern value, 0 means backdrop |
| out_valid | output | 1 | Colour output valid |
| out_color | output | 6 | Resolved colour index |
| out_emph | output | 3 | Emphasis bits aligned with out_color |

## Verification
The bench builds the block with its default parameters: a 14-bit address, 6-bit colours and a 5-bit index. With these, all 32 index values, the four shared slots and the mirrored copies up to 0x3FFF can be reached with direct addresses. A scoreboard models the palette, the read buffer and the backdrop choice from the requirements. It covers backdrop selection under rendering on and off, with the address both inside and outside the palette page, and grayscale on both the pixel and CPU paths.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int PAL_ADDR_W  = 14;
    localparam int PAL_DATA_W  = 8;
    localparam int PAL_COLOR_W = 6;
    localparam int PAL_IDX_W   = 5;

    // One renderer request
    typedef struct packed {
        logic       sprite;
        logic [1:0] sel;
        logic [1:0] bits;
    } pix_req_t;

    // Shared-slot folding: an index with low two bits zero always lives in the lower half
    function automatic logic [PAL_IDX_W-1:0] fold_index(input logic [PAL_IDX_W-1:0] raw);
        logic [PAL_IDX_W-1:0] r;
        r = raw;
        if (raw[1:0] == 2'b00) r[PAL_IDX_W-1] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/pal_addr_decode.sv
module pal_addr_decode
    import pal_pkg::*;
#(
    parameter int ADDR_W = PAL_ADDR_W,
    parameter int IDX_W  = PAL_IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_page,
    output logic [IDX_W-1:0]  idx
);
    localparam int PAGE_W = ADDR_W - 8;
    localparam logic [PAGE_W-1:0] PAGE_ID = {PAGE_W{1'b1}};

    logic unused_mirror_bits;

    assign in_page = (addr[ADDR_W-1:8] == PAGE_ID);
    assign idx     = fold_index(addr[IDX_W-1:0]);
    assign unused_mirror_bits = ^addr[7:IDX_W];
endmodule

// File: rtl/pal_entry_array.sv
module pal_entry_array
    import pal_pkg::*;
#(
    parameter int COLOR_W = PAL_COLOR_W,
    parameter int IDX_W   = PAL_IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [COLOR_W-1:0] wdata,
    input  logic [IDX_W-1:0]   pix_idx,
    input  logic [IDX_W-1:0]   addr_idx,
    output logic [COLOR_W-1:0] pix_entry,
    output logic [COLOR_W-1:0] addr_entry,
    output logic [COLOR_W-1:0] zero_entry
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [COLOR_W-1:0] mem [ENTRIES];
    logic [ENTRIES-1:0] hit;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_hit
        assign hit[e] = we && (widx == IDX_W'(e));
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (rst)         mem[e] <= '0;
            else if (hit[e]) mem[e] <= wdata;
        end
    end

    assign pix_entry  = mem[pix_idx];
    assign addr_entry = mem[addr_idx];
    assign zero_entry = mem[0];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(widx)] == $past(wdata)));   // R2
endmodule

// File: rtl/pal_cpu_port.sv
module pal_cpu_port
    import pal_pkg::*;
#(
    parameter int DATA_W  = PAL_DATA_W,
    parameter int COLOR_W = PAL_COLOR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic               in_page,
    input  logic               gray,
    input  logic [COLOR_W-1:0] entry,
    input  logic [DATA_W-1:0]  vram_rdata,
    output logic [DATA_W-1:0]  rdata
);
    localparam logic [COLOR_W-1:0] GRAY_KEEP = {2'b11, {(COLOR_W-2){1'b0}}};

    logic [DATA_W-1:0]  rd_buf;
    logic [COLOR_W-1:0] shown;

    always_ff @(posedge clk) begin
        if (rst)                      rd_buf <= '0;
        else if (rd_en && !in_page)   rd_buf <= vram_rdata;
    end

    assign shown = gray ? (entry & GRAY_KEEP) : entry;
    assign rdata = in_page ? {{(DATA_W-COLOR_W){1'b0}}, shown} : rd_buf;

    AST_PAL_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        in_page |-> (rdata[DATA_W-1:COLOR_W] == '0));   // R2
    AST_GRAY_READBACK: assert property (@(posedge clk) disable iff (rst)
        (in_page && gray) |-> (rdata[COLOR_W-3:0] == '0));   // R11
    AST_BUFFER_DELAY: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !in_page) |=> (in_page || rdata == $past(vram_rdata)));   // R5
endmodule

// File: rtl/pal_pixel_stage.sv
module pal_pixel_stage
    import pal_pkg::*;
#(
    parameter int COLOR_W = PAL_COLOR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_valid,
    input  pix_req_t           req,
    input  logic               use_addr,
    input  logic [COLOR_W-1:0] pix_entry,
    input  logic [COLOR_W-1:0] addr_entry,
    input  logic [COLOR_W-1:0] zero_entry,
    input  logic               gray,
    input  logic [2:0]         emph,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_color,
    output logic [2:0]         out_emph
);
    localparam logic [COLOR_W-1:0] GRAY_KEEP = {2'b11, {(COLOR_W-2){1'b0}}};

    typedef struct packed {
        logic               valid;
        logic [COLOR_W-1:0] color;
        logic [2:0]         emph;
    } pix_out_t;

    logic [COLOR_W-1:0] backdrop;
    logic [COLOR_W-1:0] chosen;
    logic [COLOR_W-1:0] keep;
    pix_out_t           nxt, cur;

    assign backdrop = use_addr ? addr_entry : zero_entry;
    assign chosen   = (req.bits == 2'b00) ? backdrop : pix_entry;
    assign keep     = gray ? GRAY_KEEP : {COLOR_W{1'b1}};

    always_comb begin
        nxt.valid = pix_valid;
        nxt.color = chosen & keep;
        nxt.emph  = emph;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign out_valid = cur.valid;
    assign out_color = cur.color;
    assign out_emph  = cur.emph;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);   // R6
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid);   // R6
    AST_ENTRY_ZERO_BACKDROP: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !use_addr && req.bits == 2'b00)
            |=> (out_color == ($past(zero_entry) & $past(keep))));   // R7
    AST_ADDR_BACKDROP: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && use_addr && req.bits == 2'b00)
            |=> (out_color == ($past(addr_entry) & $past(keep))));   // R8
    AST_GRAY_PIXEL: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && gray) |=> (out_color[COLOR_W-3:0] == '0));   // R10
    AST_EMPH_ALIGN: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> (out_emph == $past(emph)));   // R12
endmodule

// File: rtl/video_palette.sv
module video_palette
    import pal_pkg::*;
#(
    parameter int ADDR_W  = PAL_ADDR_W,
    parameter int DATA_W  = PAL_DATA_W,
    parameter int COLOR_W = PAL_COLOR_W,
    parameter int IDX_W   = PAL_IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_wr_en,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_rd_en,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic [DATA_W-1:0]  vram_rdata,
    input  logic               render_en,
    input  logic [7:0]         disp_ctrl,
    input  logic               pix_valid,
    input  logic               pix_sprite,
    input  logic [1:0]         pix_sel,
    input  logic [1:0]         pix_bits,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_color,
    output logic [2:0]         out_emph
);
    logic               addr_in_page;
    logic [IDX_W-1:0]   addr_idx;
    logic [IDX_W-1:0]   pix_idx;
    logic [COLOR_W-1:0] pix_entry, addr_entry, zero_entry;
    logic               gray;
    logic [2:0]         emph;
    logic               pal_we;
    pix_req_t           req;
    logic               unused_ctrl_bits;
    logic               unused_wdata_hi;

    assign gray   = disp_ctrl[0];
    assign emph   = disp_ctrl[7:5];
    assign pal_we = cpu_wr_en && addr_in_page;
    assign req    = '{sprite: pix_sprite, sel: pix_sel, bits: pix_bits};
    assign pix_idx = fold_index({req.sprite, req.sel, req.bits});
    assign unused_ctrl_bits = ^disp_ctrl[4:1];
    assign unused_wdata_hi  = ^cpu_wdata[DATA_W-1:COLOR_W];

    pal_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
        .addr    (cpu_addr),
        .in_page (addr_in_page),
        .idx     (addr_idx)
    );

    pal_entry_array #(.COLOR_W(COLOR_W), .IDX_W(IDX_W)) u_array (
        .clk        (clk),
        .rst        (rst),
        .we         (pal_we),
        .widx       (addr_idx),
        .wdata      (cpu_wdata[COLOR_W-1:0]),
        .pix_idx    (pix_idx),
        .addr_idx   (addr_idx),
        .pix_entry  (pix_entry),
        .addr_entry (addr_entry),
        .zero_entry (zero_entry)
    );

    pal_cpu_port #(.DATA_W(DATA_W), .COLOR_W(COLOR_W)) u_cpu (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (cpu_rd_en),
        .in_page    (addr_in_page),
        .gray       (gray),
        .entry      (addr_entry),
        .vram_rdata (vram_rdata),
        .rdata      (cpu_rdata)
    );

    pal_pixel_stage #(.COLOR_W(COLOR_W)) u_pixel (
        .clk        (clk),
        .rst        (rst),
        .pix_valid  (pix_valid),
        .req        (req),
        .use_addr   (!render_en && addr_in_page),
        .pix_entry  (pix_entry),
        .addr_entry (addr_entry),
        .zero_entry (zero_entry),
        .gray       (gray),
        .emph       (emph),
        .out_valid  (out_valid),
        .out_color  (out_color),
        .out_emph   (out_emph)
    );

    AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !pal_we |=> $stable(zero_entry));   // R13
endmodule

// File: tb/video_palette_test.sv
module video_palette_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] cpu_addr = '0;
    logic        cpu_wr_en = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd_en = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [7:0]  vram_rdata = '0;
    logic        render_en = 1'b0;
    logic [7:0]  disp_ctrl = '0;
    logic        pix_valid = 1'b0;
    logic        pix_sprite = 1'b0;
    logic [1:0]  pix_sel = '0;
    logic [1:0]  pix_bits = '0;
    logic        out_valid;
    logic [5:0]  out_color;
    logic [2:0]  out_emph;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] col;
        logic [2:0] emph;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [5:0] model [32];
    logic [7:0] model_buf;

    always #(CLK_PERIOD/2) clk = ~clk;

    video_palette uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr_en(cpu_wr_en),
        .cpu_wdata(cpu_wdata), .cpu_rd_en(cpu_rd_en), .cpu_rdata(cpu_rdata),
        .vram_rdata(vram_rdata), .render_en(render_en), .disp_ctrl(disp_ctrl),
        .pix_valid(pix_valid), .pix_sprite(pix_sprite), .pix_sel(pix_sel),
        .pix_bits(pix_bits), .out_valid(out_valid), .out_color(out_color),
        .out_emph(out_emph)
    );

    function automatic int slot(input logic [13:0] a);
        logic [4:0] i;
        i = a[4:0];
        if (i[1:0] == 2'b00) i[4] = 1'b0;
        return int'(i);
    endfunction

    function automatic bit in_pal(input logic [13:0] a);
        return a[13:8] == 6'h3F;
    endfunction

    function automatic logic [5:0] gmask(input logic [5:0] c);
        return disp_ctrl[0] ? (c & 6'h30) : c;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr_en = 1'b1;
        if (in_pal(a)) model[slot(a)] = d[5:0];
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic cpu_read(input string req, input logic [13:0] a, input logic [7:0] v);
        logic [7:0] exp;
        @(negedge clk);
        cpu_addr = a; vram_rdata = v; cpu_rd_en = 1'b1;
        #1;
        if (in_pal(a)) exp = {2'b00, gmask(model[slot(a)])};
        else begin
            exp = model_buf;
            model_buf = v;
        end
        check(req, cpu_rdata, exp);
        @(negedge clk);
        cpu_rd_en = 1'b0;
    endtask

    task automatic drive_pix(input string req, input logic sp, input logic [1:0] sel,
                             input logic [1:0] bits);
        exp_t e;
        logic [5:0] c;
        @(negedge clk);
        pix_sprite = sp; pix_sel = sel; pix_bits = bits; pix_valid = 1'b1;
        if (bits != 2'b00) c = model[slot({9'd0, sp, sel, bits})];
        else if (!render_en && in_pal(cpu_addr)) c = model[slot(cpu_addr)];
        else c = model[0];
        e.col = gmask(c); e.emph = disp_ctrl[7:5]; e.tag = req;
        exp_q.push_back(e);
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever a colour comes out
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R6 actual=unexpected_output expected=no_output");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " colour"}, {2'b00, out_color}, {2'b00, e.col});
                check({e.tag, " R12 emphasis"}, {5'd0, out_emph}, {5'd0, e.emph});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        model_buf = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check("R1 out_valid", {7'd0, out_valid}, 8'h00);
        cpu_read("R1 entry0", 14'h3F00, 8'h00);
        cpu_read("R1 entry31", 14'h3F1F, 8'h00);
        cpu_read("R1 buffer", 14'h2000, 8'hAB);

        // R2 / R3: fill every address, aliases overwrite their partners
        for (int i = 0; i < 32; i++)
            cpu_write(14'h3F00 + 14'(i), 8'hC0 | 8'((i * 11 + 5) & 63));
        for (int i = 0; i < 32; i++) begin
            if (i[1:0] == 2'b00) cpu_read("R3 shared slot", 14'h3F00 + 14'(i), 8'h00);
            else                 cpu_read("R2 readback", 14'h3F00 + 14'(i), 8'h00);
        end
        cpu_write(14'h3F04, 8'h2A);
        cpu_read("R3 read 0x14 after 0x04 write", 14'h3F14, 8'h00);

        // R4: mirrors across the page
        cpu_read("R4 mirror 0x3F25", 14'h3F25, 8'h00);
        cpu_read("R4 mirror 0x3FFF", 14'h3FFF, 8'h00);
        cpu_write(14'h3FE5, 8'h17);
        cpu_read("R4 write via mirror", 14'h3F05, 8'h00);

        // R13: foreign writes ignored
        cpu_write(14'h2005, 8'h3F);
        cpu_write(14'h3E00, 8'h01);
        for (int i = 0; i < 32; i += 5)
            cpu_read("R13 entries unchanged", 14'h3F00 + 14'(i), 8'h00);

        // R5: delayed buffer, palette reads leave it alone
        cpu_read("R5 first delayed", 14'h2100, 8'h5A);
        cpu_read("R5 palette between", 14'h3F01, 8'h77);
        cpu_read("R5 second delayed", 14'h2101, 8'h66);
        cpu_read("R5 third delayed", 14'h0010, 8'h99);

        // R6 / R7: rendering on
        render_en = 1'b1; disp_ctrl = 8'hA0;
        cpu_addr = 14'h3F07;
        drive_pix("R6 bg", 1'b0, 2'd1, 2'd3);
        drive_pix("R6 sprite", 1'b1, 2'd2, 2'd1);
        drive_pix("R6 sprite last", 1'b1, 2'd3, 2'd3);
        drive_pix("R7 backdrop render on", 1'b1, 2'd2, 2'd0);

        // R8 / R9: rendering off
        render_en = 1'b0; disp_ctrl = 8'h40;
        cpu_addr = 14'h3F07;
        drive_pix("R8 addr backdrop", 1'b0, 2'd0, 2'd0);
        cpu_addr = 14'h3F14;
        drive_pix("R8 alias backdrop", 1'b0, 2'd3, 2'd0);
        cpu_addr = 14'h3FE9;
        drive_pix("R8 mirror backdrop", 1'b1, 2'd1, 2'd0);
        cpu_addr = 14'h2100;
        drive_pix("R9 outside page backdrop", 1'b0, 2'd1, 2'd0);

        // R10 / R11 / R12: grayscale and emphasis
        disp_ctrl = 8'hE1; render_en = 1'b1;
        drive_pix("R10 gray bg", 1'b0, 2'd2, 2'd2);
        drive_pix("R10 gray backdrop", 1'b0, 2'd0, 2'd0);
        cpu_read("R11 gray readback", 14'h3F05, 8'h00);
        cpu_read("R11 gray readback 2", 14'h3F1B, 8'h00);
        disp_ctrl = 8'h20;
        drive_pix("R12 emphasis change", 1'b1, 2'd0, 2'd1);

        repeat (4) @(negedge clk);
        check("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule